// File: doc/BRIEF.md
# Staged-Ratio Clock Divider Bank

This block turns one fast source clock into several slower clock-enable streams. Each output has its own divide ratio and its own gate. Each output pulses high for one source cycle at the start of every divided period. The logic that consumes a stream uses the pulse as a clock enable, and all outputs stay in the source clock domain.

Software writes new ratios into pending registers, which do not disturb the running outputs. When every pending value is in place, software writes the apply command. On that command, all dividers take their new ratios together and restart from a common edge, so the divided streams stay phase-aligned. A status bit stays set for the whole transition. Divider writes made while it is set are dropped and raise a sticky error flag.

Top module: `clkdiv_bank`

## Requirements
- R1: After a synchronous reset, every divider register reads 0, the status register reads 0, and every output is low.
- R2: A divider register holds the ratio in bits 4:0 and the output enable in bit 15. Every other bit reads 0. A read returns the pending value last written.
- R3: An enabled output pulses for one cycle every ratio+1 source cycles, where ratio is the value taken at the last apply command.
- R4: Writing a ratio into a divider register does not change the running output period until an apply command is issued.
- R5: Writing 1 to bit 0 of the command register (offset 0x00) while idle loads every pending ratio and restarts every divider. Every enabled output pulses in the first cycle after the write, and the outputs stay phase-aligned from then on.
- R6: Bit 0 of the status register (offset 0x04) reads 1 for exactly M+1+SETTLE_CYC cycles after the apply write, then reads 0. M is the largest pending ratio among the enabled dividers, or 0 when none is enabled.
- R7: A divider register write made while bit 0 of the status register is 1 is ignored and sets status bit 1. Status bit 1 stays set until software writes 1 to bit 1 of the status register.
- R8: The enable bit acts at once. Clearing it forces the output low from the next cycle, while the divider keeps counting, so re-enabling it resumes the original phase.
- R9: Dividers 1 to 3 sit at byte offsets 0x10, 0x14 and 0x18. Divider 4 onward sits at 0x40 + 4·(n−4). Reads of unmapped offsets return 0, and writes to them change nothing.
- R10: An apply command written while the status bit is 1 is ignored and does not restart the transition timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock (divider reference) |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on reg_addr) |
| div_en_o | output | NUM_DIV | Per-divider one-cycle clock-enable pulses |

## Verification
The bench aims at the transition window. It checks the exact length of the busy interval when the largest ratio sits on a disabled divider, which a design that ignores the enables would stretch. It also checks that a repeated apply command made mid-transition does not extend the interval, which a design that restarts its timer would fail. A divider write made during the window must leave the register unchanged and raise the error flag. A design that let the write through would show the new value on read-back. Random ratio and enable mixes are then compared pulse-for-pulse against a model from the first cycle after the apply command, which exposes dividers that restart one cycle apart. Separate cases check that the period holds until an apply command, and that gating an output keeps its phase.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 16;
    localparam int RATIO_W  = 5;
    localparam int EN_BIT   = 15;
    localparam int IDX_W    = 8;

    localparam int CMD_OFS   = 'h00;
    localparam int STAT_OFS  = 'h04;
    localparam int LO_BASE   = 'h10;
    localparam int LO_COUNT  = 3;
    localparam int HI_BASE   = 'h40;

    localparam int CMD_GO_BIT    = 0;
    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_ERR_BIT  = 1;

    typedef struct packed {
        logic               enable;
        logic [RATIO_W-1:0] ratio;
    } div_cfg_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } div_sel_t;

    // Maps a byte offset onto a divider slot; the low group and the high
    // group are separate word-spaced windows.
    function automatic div_sel_t decode_div(input logic [ADDR_W-1:0] addr,
                                            input int num);
        div_sel_t s;
        int a;
        s = '0;
        a = int'(addr);
        if ((a % 4) == 0) begin
            if (a >= LO_BASE && a < LO_BASE + 4*LO_COUNT &&
                ((a - LO_BASE) / 4) < num) begin
                s.hit = 1'b1;
                s.idx = IDX_W'((a - LO_BASE) / 4);
            end else if (num > LO_COUNT && a >= HI_BASE &&
                         a < HI_BASE + 4*(num - LO_COUNT)) begin
                s.hit = 1'b1;
                s.idx = IDX_W'((a - HI_BASE) / 4 + LO_COUNT);
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int NUM_DIV = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    input  logic                       busy,
    output div_cfg_t [NUM_DIV-1:0]     cfg_o,
    output logic                       go_o
);

    div_cfg_t [NUM_DIV-1:0] cfg_q;
    logic                   err_q;
    div_sel_t               sel;
    logic                   is_cmd;
    logic                   is_stat;
    logic                   blocked;
    logic                   err_clr;

    assign sel     = decode_div(addr, NUM_DIV);
    assign is_cmd  = (int'(addr) == CMD_OFS);
    assign is_stat = (int'(addr) == STAT_OFS);
    assign go_o    = wr_en && is_cmd && wdata[CMD_GO_BIT] && !busy;
    assign blocked = wr_en && sel.hit && busy;
    assign err_clr = wr_en && is_stat && wdata[STAT_ERR_BIT];
    assign cfg_o   = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            err_q <= 1'b0;
        end else begin
            for (int i = 0; i < NUM_DIV; i++) begin
                if (wr_en && sel.hit && !busy && sel.idx == IDX_W'(i)) begin
                    cfg_q[i].enable <= wdata[EN_BIT];
                    cfg_q[i].ratio  <= wdata[RATIO_W-1:0];
                end
            end
            if (blocked)
                err_q <= 1'b1;
            else if (err_clr)
                err_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel.hit) begin
            for (int i = 0; i < NUM_DIV; i++) begin
                if (sel.idx == IDX_W'(i)) begin
                    rdata[EN_BIT]        = cfg_q[i].enable;
                    rdata[RATIO_W-1:0]   = cfg_q[i].ratio;
                end
            end
        end else if (is_stat) begin
            rdata[STAT_BUSY_BIT] = busy;
            rdata[STAT_ERR_BIT]  = err_q;
        end
    end

    // A refused write must leave a trace in the error flag.
    assert_block_err_R7: assert property (@(posedge clk) disable iff (rst)
        blocked |=> err_q);
    // The flag only drops on an explicit clear.
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (err_q && !err_clr) |=> err_q);
    // Configuration is frozen for the whole transition window.
    assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg_q));

endmodule

// File: rtl/clkdiv_go_ctrl.sv
module clkdiv_go_ctrl
    import clkdiv_pkg::*;
#(
    parameter int NUM_DIV    = 6,
    parameter int SETTLE_CYC = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   go,
    input  div_cfg_t [NUM_DIV-1:0] cfg,
    output logic                   busy
);

    localparam int TMR_W = RATIO_W + $clog2(SETTLE_CYC + 2) + 1;

    logic [RATIO_W-1:0] slowest;
    logic [TMR_W-1:0]   load;
    logic [TMR_W-1:0]   timer;

    always_comb begin
        slowest = '0;
        for (int i = 0; i < NUM_DIV; i++) begin
            if (cfg[i].enable && cfg[i].ratio > slowest)
                slowest = cfg[i].ratio;
        end
    end

    assign load = {{(TMR_W-RATIO_W){1'b0}}, slowest} + TMR_W'(SETTLE_CYC + 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            timer <= '0;
        end else if (go) begin
            busy  <= 1'b1;
            timer <= load;
        end else if (busy) begin
            timer <= timer - TMR_W'(1);
            if (timer == TMR_W'(1))
                busy <= 1'b0;
        end
    end

    assert_go_sets_busy_R6: assert property (@(posedge clk) disable iff (rst)
        go |=> busy);
    assert_idle_timer_R6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (timer == '0));
    // Once running, the timer only counts down; nothing reloads it.
    assert_no_restart_R10: assert property (@(posedge clk) disable iff (rst)
        busy |=> (timer == $past(timer) - TMR_W'(1)));
    assert_go_only_idle_R10: assert property (@(posedge clk) disable iff (rst)
        go |-> !busy);

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
    import clkdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     go,
    input  div_cfg_t cfg,
    output logic     pulse
);

    logic [RATIO_W-1:0] active;
    logic [RATIO_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '0;
            cnt    <= '0;
        end else if (go) begin
            active <= cfg.ratio;
            cnt    <= '0;
        end else if (cnt == '0) begin
            cnt <= active;
        end else begin
            cnt <= cnt - RATIO_W'(1);
        end
    end

    assign pulse = cfg.enable && (cnt == '0);

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt <= active);
    assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
        go |=> (cnt == '0));
    assert_ratio_held_R4: assert property (@(posedge clk) disable iff (rst)
        !go |=> $stable(active));

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int NUM_DIV    = 6,
    parameter int SETTLE_CYC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [7:0]         reg_addr,
    input  logic [15:0]        reg_wdata,
    output logic [15:0]        reg_rdata,
    output logic [NUM_DIV-1:0] div_en_o
);

    div_cfg_t [NUM_DIV-1:0] cfg;
    logic                   go;
    logic                   busy;

    clkdiv_regs #(.NUM_DIV(NUM_DIV)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .busy  (busy),
        .cfg_o (cfg),
        .go_o  (go)
    );

    clkdiv_go_ctrl #(.NUM_DIV(NUM_DIV), .SETTLE_CYC(SETTLE_CYC)) u_go (
        .clk  (clk),
        .rst  (rst),
        .go   (go),
        .cfg  (cfg),
        .busy (busy)
    );

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
        clkdiv_counter u_cnt (
            .clk   (clk),
            .rst   (rst),
            .go    (go),
            .cfg   (cfg[g]),
            .pulse (div_en_o[g])
        );
    end

    assert_gated_low_R8: assert property (@(posedge clk) disable iff (rst)
        !cfg[0].enable |-> !div_en_o[0]);

endmodule

// File: tb/test_clkdiv_bank.sv
module test_clkdiv_bank;

    localparam int N      = 6;
    localparam int SETTLE = 4;
    localparam int CMD    = 'h00;
    localparam int STAT   = 'h04;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [N-1:0] div_en_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int pr [N];
    bit pe [N];

    clkdiv_bank #(.NUM_DIV(N), .SETTLE_CYC(SETTLE)) i_clkdiv_bank (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .div_en_o(div_en_o));

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    function automatic int div_addr(input int k);
        return (k < 3) ? ('h10 + 4*k) : ('h40 + 4*(k-3));
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'(a); reg_wdata = 16'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        reg_addr = 8'(a);
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic set_div(input int k, input bit en, input int r);
        wr(div_addr(k), (int'(en) << 15) | r);
        pr[k] = r; pe[k] = en;
    endtask

    // Apply, then compare every output and the busy bit against the model.
    task automatic go_and_check(input string tag);
        int mism [N];
        int busy_n, mx, v;
        mx = 0;
        for (int i = 0; i < N; i++) begin
            mism[i] = 0;
            if (pe[i] && pr[i] > mx) mx = pr[i];
        end
        busy_n = 0;
        wr(CMD, 1);
        for (int k = 0; k < 64; k++) begin
            if (k > 0) @(negedge clk);
            rd(STAT, v);
            if (v[0]) busy_n++;
            for (int i = 0; i < N; i++) begin
                if (div_en_o[i] != (pe[i] && (k % (pr[i]+1) == 0))) mism[i]++;
            end
        end
        for (int i = 0; i < N; i++)
            check(mism[i] == 0, {"R3/R5 aligned pulses ", tag}, mism[i], 0);
        check(busy_n == mx + 1 + SETTLE, {"R6 busy length ", tag}, busy_n, mx + 1 + SETTLE);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int v, c0, p0, cntp, bad;
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < N; i++) begin pr[i] = 0; pe[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(STAT, v);
        check(v == 0, "R1 status after reset", v, 0);
        bad = 0;
        for (int i = 0; i < N; i++) begin rd(div_addr(i), v); if (v != 0) bad++; end
        check(bad == 0, "R1 divider regs after reset", bad, 0);
        check(div_en_o == '0, "R1 outputs after reset", int'(div_en_o), 0);

        // R2 field layout, R9 address map
        wr(div_addr(4), 'hFFFF);
        rd(div_addr(4), v);
        check(v == 'h801F, "R2 field readback", v, 'h801F);
        rd(div_addr(3), v);
        check(v == 0, "R9 divider 4 separate from others", v, 0);
        wr('h1C, 'hFFFF);
        rd('h1C, v);
        check(v == 0, "R9 unmapped read", v, 0);
        bad = 0;
        for (int i = 0; i < N; i++) begin
            rd(div_addr(i), v);
            if (v != ((i == 4) ? 'h801F : 0)) bad++;
        end
        check(bad == 0, "R9 unmapped write no effect", bad, 0);
        wr('h18, 'h8005);
        rd(div_addr(2), v);
        check(v == 'h8005, "R9 divider 3 offset", v, 'h8005);
        for (int i = 0; i < N; i++) set_div(i, 0, 0);

        // R5/R6 directed: largest ratio on a disabled divider is ignored
        set_div(0, 1, 3); set_div(1, 1, 5); set_div(2, 0, 7);
        go_and_check("directed");

        // Random mixes
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < N; i++) set_div(i, bit'($urandom % 4 != 0), int'($urandom % 32));
            go_and_check("random");
        end

        // R4 pending ratio has no effect until apply
        for (int i = 0; i < N; i++) set_div(i, 0, 0);
        set_div(0, 1, 3);
        go_and_check("R4 setup");
        set_div(0, 1, 7);
        cntp = 0;
        for (int k = 0; k < 16; k++) begin
            if (k > 0) @(negedge clk);
            if (div_en_o[0]) cntp++;
        end
        check(cntp == 4, "R4 old period kept", cntp, 4);
        rd(div_addr(0), v);
        check(v == 'h8007, "R2 pending readback", v, 'h8007);
        go_and_check("R4 applied");

        // R8 gate is immediate and phase is preserved
        @(negedge clk);
        while (!div_en_o[0]) @(negedge clk);
        p0 = cyc;
        wr(div_addr(0), 'h0007);
        cntp = 0;
        for (int k = 0; k < 24; k++) begin
            if (k > 0) @(negedge clk);
            if (div_en_o[0]) cntp++;
        end
        check(cntp == 0, "R8 gated output low", cntp, 0);
        wr(div_addr(0), 'h8007);
        while (!div_en_o[0]) @(negedge clk);
        check((cyc - p0) % 8 == 0, "R8 phase kept", (cyc - p0) % 8, 0);

        // R7 blocked write, R10 repeated apply ignored
        for (int i = 0; i < N; i++) set_div(i, 0, 0);
        set_div(0, 1, 20);
        wr(CMD, 1);
        c0 = cyc;
        wr(div_addr(1), 'h8009);
        wr(CMD, 1);
        rd(STAT, v);
        while (v[0]) begin @(negedge clk); rd(STAT, v); end
        check(cyc - c0 == 25, "R10 busy not restarted", cyc - c0, 25);
        check(v == 2, "R7 error flag set", v, 2);
        rd(div_addr(1), v);
        check(v == 0, "R7 blocked write ignored", v, 0);
        wr(STAT, 2);
        rd(STAT, v);
        check(v == 0, "R7 error flag cleared", v, 0);
        wr(div_addr(1), 'h8009);
        rd(STAT, v);
        check(v == 0, "R7 idle write no error", v, 0);
        rd(div_addr(1), v);
        check(v == 'h8009, "R7 idle write accepted", v, 'h8009);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule